// File: doc/BRIEF.md
# Control Endpoint Status Handshake

This block keeps the status and control byte of the default control endpoint and settles the handshake between firmware and the bus side of a USB device. The bus side presents one token per cycle (SETUP, OUT or IN, each with a byte count). Firmware writes the status byte, loads or drains data bytes one at a time, and acknowledges the interrupt. The block answers each token with ACK, NAK or STALL, updates the status byte, and raises the endpoint interrupt when firmware has work to do.

The endpoint data buffer is modelled only as a byte count. An accepted SETUP or OUT token adds its length to the count, and an acknowledged IN token empties it. A 4-bit maximum-packet field is held next to the status byte. Status bits sit at fixed positions in the byte read by firmware: bit 0 receive-ready, bit 1 transmit-ready, bit 2 stall-was-sent, bit 3 last-data, bit 4 setup-abort, bit 5 stall-request, bit 6 receive-done command, bit 7 abort-done command.

Top module: `ctl_ep_handshake`

## Requirements
- R1: After reset the status byte reads 0x00, the byte count is 0, the interrupt is low, no handshake is valid and the maximum-packet field reads 1.
- R2: A firmware write ORs bits 1 and 3 into the status byte, so writing 0 never clears them. Bit 2 is kept only where the written bit is 1 and is never set by a write. Bit 5 takes the written value. Writes never set bits 0 and 4. Bits 6 and 7 always read 0.
- R3: Writing 1 to bit 7 clears bit 4, and writing 1 to bit 6 clears bit 0.
- R4: A SETUP (tok_kind 0) or OUT (tok_kind 1) token while bit 5 is set is answered with STALL (hs_code 2). It sets bit 2, raises the interrupt and leaves the byte count unchanged.
- R5: Otherwise, a SETUP or OUT token is answered with ACK (hs_code 0). It sets bit 0, raises the interrupt and adds its length to the byte count. With the default options the count saturates at FIFO_DEPTH.
- R6: A SETUP or OUT token that arrives while bit 0 is set pulses overrun together with its handshake.
- R7: An IN token (tok_kind 2) while bit 5 is set is answered with STALL, sets bit 2 and raises the interrupt.
- R8: An IN token while bit 1 is clear is answered with NAK (hs_code 1). It leaves the interrupt unchanged and records the token length as the pending request.
- R9: An IN token while bit 1 is set is answered with ACK. It empties the byte count, clears bits 1 and 3, clears the pending request and raises the interrupt.
- R10: A write with bit 1 set, while a request is pending, the byte count is below it and bit 3 stays clear, leaves bit 1 clear and raises the interrupt so firmware can load more bytes.
- R11: An accepted SETUP token that arrives while bit 1 or bit 3 is set sets bit 4 and clears bits 1 and 3.
- R12: The maximum-packet field keeps the low 4 bits of each write to it.
- R13: The interrupt stays high until irq_clr. A new interrupt event in the same cycle as irq_clr wins.
- R14: byte_push and byte_pop change the count by one, with no rise above FIFO_DEPTH or fall below 0. A firmware write and a token in the same cycle act as if the write came first. All results show on the outputs in the cycle after the inputs, and hs_valid is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | 0 SETUP, 1 OUT, 2 IN |
| tok_len | input | LEN_W | Bytes carried (SETUP/OUT) or requested (IN) |
| csr_wr_en | input | 1 | Firmware write of the status byte |
| csr_wr_data | input | 8 | Write data for the status byte |
| maxp_wr_en | input | 1 | Firmware write of the maximum-packet field |
| maxp_wr_data | input | 8 | Write data; low 4 bits kept |
| byte_push | input | 1 | Firmware loads one byte |
| byte_pop | input | 1 | Firmware drains one byte |
| irq_clr | input | 1 | Interrupt acknowledge |
| csr_rd | output | 8 | Current status byte |
| maxp | output | 4 | Maximum-packet field |
| fifo_cnt | output | CNT_W | Bytes held in the endpoint buffer |
| irq | output | 1 | Endpoint interrupt request |
| hs_valid | output | 1 | Handshake result valid |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |
| overrun | output | 1 | Receive token arrived with bit 0 still set |

## Verification
Every cycle, the bound checker checks that the stall-was-sent bit only rises after a token, never after a write alone. It also checks that each handshake follows a token by one cycle, that STALL always comes with bit 2 set and NAK only answers IN, that overrun only follows a set receive-ready bit, that the count stays within FIFO_DEPTH and that the command bits read 0. The write-merge rules, the partial-load re-interrupt, the setup-abort case, saturation and the write-before-token ordering need specific sequences of writes and tokens. Only the directed scenarios of the bench show those.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

   typedef enum logic [1:0] {
      TOK_SETUP = 2'd0,
      TOK_OUT   = 2'd1,
      TOK_IN    = 2'd2
   } tok_kind_e;

   typedef enum logic [1:0] {
      HS_ACK   = 2'd0,
      HS_NAK   = 2'd1,
      HS_STALL = 2'd2
   } hs_code_e;

   // status byte bit positions (firmware decodes these)
   localparam int B_RXRDY  = 0;
   localparam int B_TXRDY  = 1;
   localparam int B_STSENT = 2;
   localparam int B_LAST   = 3;
   localparam int B_ABORT  = 4;
   localparam int B_STREQ  = 5;
   localparam int B_RXDONE = 6;
   localparam int B_ABDONE = 7;

endpackage

// File: rtl/ep0_csr_merge.sv
module ep0_csr_merge
   import ctl_ep_pkg::*;
#(
   parameter int LEN_W = 8,
   parameter int CNT_W = 5
) (
   input  logic [7:0]       csr_q,
   input  logic             wr_en,
   input  logic [7:0]       wd,
   input  logic [LEN_W-1:0] req_q,
   input  logic [CNT_W-1:0] cnt_q,
   output logic [7:0]       csr_m,
   output logic             part_irq
);

   logic [LEN_W-1:0] cnt_ext;
   logic             unused_wd_bits;

   assign cnt_ext        = LEN_W'(cnt_q);
   assign unused_wd_bits = ^{wd[B_RXRDY], wd[B_ABORT]};

   always_comb begin
      csr_m    = csr_q;
      part_irq = 1'b0;
      if (wr_en) begin
         csr_m[B_TXRDY]  = csr_q[B_TXRDY] | wd[B_TXRDY];
         csr_m[B_LAST]   = csr_q[B_LAST]  | wd[B_LAST];
         csr_m[B_STSENT] = csr_q[B_STSENT] & wd[B_STSENT];
         csr_m[B_STREQ]  = wd[B_STREQ];
         if (wd[B_RXDONE]) csr_m[B_RXRDY] = 1'b0;
         if (wd[B_ABDONE]) csr_m[B_ABORT] = 1'b0;
         if (wd[B_TXRDY] && !csr_m[B_LAST] &&
             (req_q != '0) && (cnt_ext < req_q)) begin
            csr_m[B_TXRDY] = 1'b0;
            part_irq       = 1'b1;
         end
      end
      csr_m[B_RXDONE] = 1'b0;
      csr_m[B_ABDONE] = 1'b0;
   end

endmodule

// File: rtl/ep0_token_eng.sv
module ep0_token_eng
   import ctl_ep_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic             tok_valid,
   input  logic [1:0]       tok_kind,
   input  logic [LEN_W-1:0] tok_len,
   input  logic [7:0]       csr_m,
   input  logic [LEN_W-1:0] req_q,
   output logic [7:0]       csr_n,
   output logic [LEN_W-1:0] req_n,
   output logic             add_en,
   output logic             drain,
   output logic             irq_set,
   output logic             hs_fire,
   output hs_code_e         hs_kind,
   output logic             ovr
);

   always_comb begin
      csr_n   = csr_m;
      req_n   = req_q;
      add_en  = 1'b0;
      drain   = 1'b0;
      irq_set = 1'b0;
      hs_fire = 1'b0;
      hs_kind = HS_ACK;
      ovr     = 1'b0;
      if (tok_valid) begin
         unique case (tok_kind)
            TOK_SETUP, TOK_OUT: begin
               hs_fire = 1'b1;
               ovr     = csr_m[B_RXRDY];
               irq_set = 1'b1;
               if (csr_m[B_STREQ]) begin
                  hs_kind          = HS_STALL;
                  csr_n[B_STSENT]  = 1'b1;
               end else begin
                  hs_kind         = HS_ACK;
                  add_en          = 1'b1;
                  csr_n[B_RXRDY]  = 1'b1;
                  if (tok_kind == TOK_SETUP) begin
                     req_n = '0;
                     if (csr_m[B_TXRDY] || csr_m[B_LAST]) csr_n[B_ABORT] = 1'b1;
                     csr_n[B_TXRDY] = 1'b0;
                     csr_n[B_LAST]  = 1'b0;
                  end
               end
            end
            TOK_IN: begin
               hs_fire = 1'b1;
               if (csr_m[B_STREQ]) begin
                  hs_kind         = HS_STALL;
                  csr_n[B_STSENT] = 1'b1;
                  irq_set         = 1'b1;
               end else if (!csr_m[B_TXRDY]) begin
                  hs_kind = HS_NAK;
                  req_n   = tok_len;
               end else begin
                  hs_kind        = HS_ACK;
                  drain          = 1'b1;
                  csr_n[B_TXRDY] = 1'b0;
                  csr_n[B_LAST]  = 1'b0;
                  req_n          = '0;
                  irq_set        = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ep0_byte_ctr.sv
module ep0_byte_ctr #(
   parameter int FIFO_DEPTH = 16,
   parameter int CNT_W      = 5,
   parameter int LEN_W      = 8,
   parameter bit SATURATE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             add_en,
   input  logic [LEN_W-1:0] add_len,
   input  logic             drain,
   output logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);
   localparam logic [LEN_W:0]   DEPTH_L = (LEN_W+1)'(FIFO_DEPTH);

   logic [LEN_W:0] mid, sum, added, nxt;

   always_comb begin
      mid = (LEN_W+1)'(cnt_q);
      if (push && !pop && (cnt_q < DEPTH_C))
         mid = mid + 1'b1;
      else if (pop && !push && (cnt_q != '0))
         mid = mid - 1'b1;
      sum = mid + {1'b0, add_len};
   end

   generate
      if (SATURATE) begin : g_sat
         assign added = (sum > DEPTH_L) ? DEPTH_L : sum;
      end else begin : g_drop
         assign added = (sum > DEPTH_L) ? mid : sum;
      end
   endgenerate

   always_comb begin
      if (drain)       nxt = '0;
      else if (add_en) nxt = added;
      else             nxt = mid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= CNT_W'(nxt);
   end

endmodule

// File: rtl/ctl_ep_handshake.sv
module ctl_ep_handshake
   import ctl_ep_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int LEN_W      = 8,
   parameter bit SATURATE   = 1'b1,
   parameter bit HS_REG     = 1'b1,
   parameter int MAXP_RST   = 1,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok_valid,
   input  logic [1:0]       tok_kind,
   input  logic [LEN_W-1:0] tok_len,
   input  logic             csr_wr_en,
   input  logic [7:0]       csr_wr_data,
   input  logic             maxp_wr_en,
   input  logic [7:0]       maxp_wr_data,
   input  logic             byte_push,
   input  logic             byte_pop,
   input  logic             irq_clr,
   output logic [7:0]       csr_rd,
   output logic [3:0]       maxp,
   output logic [CNT_W-1:0] fifo_cnt,
   output logic             irq,
   output logic             hs_valid,
   output logic [1:0]       hs_code,
   output logic             overrun
);

   generate
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 1");
      end
      if (LEN_W < CNT_W) begin : g_bad_len
         $error("LEN_W must cover the byte count width");
      end
      if (MAXP_RST < 0 || MAXP_RST > 15) begin : g_bad_maxp
         $error("MAXP_RST must fit in 4 bits");
      end
   endgenerate

   logic [7:0]       csr_q, csr_m, csr_n;
   logic [LEN_W-1:0] req_q, req_n;
   logic [3:0]       maxp_q;
   logic             irq_q;
   logic             part_irq, add_en, drain, irq_set, hs_fire, ovr;
   hs_code_e         hs_kind;
   logic [CNT_W-1:0] cnt_q;
   logic [3:0]       unused_maxp_hi;

   assign unused_maxp_hi = maxp_wr_data[7:4];

   ep0_csr_merge #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_merge (
      .csr_q    (csr_q),
      .wr_en    (csr_wr_en),
      .wd       (csr_wr_data),
      .req_q    (req_q),
      .cnt_q    (cnt_q),
      .csr_m    (csr_m),
      .part_irq (part_irq)
   );

   ep0_token_eng #(.LEN_W(LEN_W)) u_tok (
      .tok_valid (tok_valid),
      .tok_kind  (tok_kind),
      .tok_len   (tok_len),
      .csr_m     (csr_m),
      .req_q     (req_q),
      .csr_n     (csr_n),
      .req_n     (req_n),
      .add_en    (add_en),
      .drain     (drain),
      .irq_set   (irq_set),
      .hs_fire   (hs_fire),
      .hs_kind   (hs_kind),
      .ovr       (ovr)
   );

   ep0_byte_ctr #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .CNT_W      (CNT_W),
      .LEN_W      (LEN_W),
      .SATURATE   (SATURATE)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (byte_push),
      .pop     (byte_pop),
      .add_en  (add_en),
      .add_len (tok_len),
      .drain   (drain),
      .cnt_q   (cnt_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csr_q  <= '0;
         req_q  <= '0;
         maxp_q <= 4'(MAXP_RST);
         irq_q  <= 1'b0;
      end else begin
         csr_q <= csr_n;
         req_q <= req_n;
         if (maxp_wr_en) maxp_q <= maxp_wr_data[3:0];
         if (irq_set || part_irq) irq_q <= 1'b1;
         else if (irq_clr)        irq_q <= 1'b0;
      end
   end

   generate
      if (HS_REG) begin : g_hs_reg
         logic       hsv_q, ovr_q;
         logic [1:0] hsc_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hsv_q <= 1'b0;
               hsc_q <= HS_ACK;
               ovr_q <= 1'b0;
            end else begin
               hsv_q <= hs_fire;
               hsc_q <= hs_kind;
               ovr_q <= ovr;
            end
         end
         assign hs_valid = hsv_q;
         assign hs_code  = hsc_q;
         assign overrun  = ovr_q;
      end else begin : g_hs_comb
         assign hs_valid = hs_fire;
         assign hs_code  = hs_kind;
         assign overrun  = ovr;
      end
   endgenerate

   assign csr_rd   = csr_q;
   assign maxp     = maxp_q;
   assign fifo_cnt = cnt_q;
   assign irq      = irq_q;

endmodule

// File: rtl/ctl_ep_handshake_chk.sv
module ctl_ep_handshake_chk #(
   parameter int FIFO_DEPTH = 16,
   parameter int LEN_W      = 8,
   parameter bit HS_REG     = 1'b1,
   parameter int CNT_W      = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tok_valid,
   input logic [1:0]       tok_kind,
   input logic             csr_wr_en,
   input logic [7:0]       csr_rd,
   input logic [CNT_W-1:0] fifo_cnt,
   input logic             irq,
   input logic             hs_valid,
   input logic [1:0]       hs_code,
   input logic             overrun
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

   // R2: writes never raise the stall-was-sent bit
   assert_stall_sent_by_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csr_rd[2]) |-> $past(tok_valid));

   // R4 / R7: STALL is always reported with stall-was-sent set
   assert_stall_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_code == 2'd2) |-> csr_rd[2]);

   // R8: NAK only answers IN tokens
   assert_nak_only_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_code == 2'd1) |-> $past(tok_kind) == 2'd2);

   // R6: overrun needs receive-ready set when the token came
   assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> (hs_valid && $past(csr_rd[0])));

   // R13: interrupt rises only after a token or a write
   assert_irq_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(tok_valid) || $past(csr_wr_en)));

   // R14: count bounded by depth
   assert_cnt_bound_R14: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= DEPTH_C);

   // R2: command bits read zero
   assert_cmd_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rd[7:6] == 2'b00);

   generate
      if (HS_REG) begin : g_hs_timing
         // R14: handshake one cycle after its token, never two in a row without tokens
         assert_hs_follows_tok_R14: assert property (@(posedge clk) disable iff (!rst_n)
            hs_valid |-> $past(tok_valid));
      end
   endgenerate

endmodule

bind ctl_ep_handshake ctl_ep_handshake_chk #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .LEN_W      (LEN_W),
   .HS_REG     (HS_REG),
   .CNT_W      (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tok_valid (tok_valid),
   .tok_kind  (tok_kind),
   .csr_wr_en (csr_wr_en),
   .csr_rd    (csr_rd),
   .fifo_cnt  (fifo_cnt),
   .irq       (irq),
   .hs_valid  (hs_valid),
   .hs_code   (hs_code),
   .overrun   (overrun)
);

// File: tb/tb_ctl_ep_handshake.sv
module tb_ctl_ep_handshake;

   localparam int DEPTH = 16;
   localparam int LW    = 8;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tok_valid = 1'b0;
   logic [1:0]    tok_kind = 2'd0;
   logic [LW-1:0] tok_len = '0;
   logic          csr_wr_en = 1'b0;
   logic [7:0]    csr_wr_data = '0;
   logic          maxp_wr_en = 1'b0;
   logic [7:0]    maxp_wr_data = '0;
   logic          byte_push = 1'b0;
   logic          byte_pop = 1'b0;
   logic          irq_clr = 1'b0;
   logic [7:0]    csr_rd;
   logic [3:0]    maxp;
   logic [CW-1:0] fifo_cnt;
   logic          irq;
   logic          hs_valid;
   logic [1:0]    hs_code;
   logic          overrun;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   ctl_ep_handshake #(.FIFO_DEPTH(DEPTH), .LEN_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
      .tok_len(tok_len), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
      .maxp_wr_en(maxp_wr_en), .maxp_wr_data(maxp_wr_data),
      .byte_push(byte_push), .byte_pop(byte_pop), .irq_clr(irq_clr),
      .csr_rd(csr_rd), .maxp(maxp), .fifo_cnt(fifo_cnt), .irq(irq),
      .hs_valid(hs_valid), .hs_code(hs_code), .overrun(overrun)
   );

   always #5 clk = ~clk;

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 5000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles, expected below 5000", cycles);
         finish_run();
      end
   end

   task automatic chk(string req, int act, int exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      tok_valid = 1'b0; csr_wr_en = 1'b0; maxp_wr_en = 1'b0;
      byte_push = 1'b0; byte_pop = 1'b0; irq_clr = 1'b0;
   endtask

   task automatic tok(logic [1:0] k, int n);
      tok_valid = 1'b1; tok_kind = k; tok_len = LW'(n);
      cyc();
   endtask

   task automatic wr(logic [7:0] v);
      csr_wr_en = 1'b1; csr_wr_data = v;
      cyc();
   endtask

   task automatic clr_irq();
      irq_clr = 1'b1;
      cyc();
   endtask

   task automatic push_n(int n);
      for (int i = 0; i < n; i++) begin byte_push = 1'b1; cyc(); end
   endtask

   task automatic pop_n(int n);
      for (int i = 0; i < n; i++) begin byte_pop = 1'b1; cyc(); end
   endtask

   task automatic t_reset();
      chk("R1 csr", csr_rd, 8'h00);
      chk("R1 cnt", fifo_cnt, 0);
      chk("R1 irq", irq, 0);
      chk("R1 hs_valid", hs_valid, 0);
      chk("R1 maxp", maxp, 1);
   endtask

   task automatic t_maxp();
      maxp_wr_en = 1'b1; maxp_wr_data = 8'hA7;
      cyc();
      chk("R12 maxp low nibble", maxp, 7);
   endtask

   task automatic t_out_accept();
      tok(2'd1, 5);
      chk("R5 hs", {hs_valid, hs_code}, 3'b100);
      chk("R5 csr", csr_rd, 8'h01);
      chk("R5 cnt", fifo_cnt, 5);
      chk("R5 irq", irq, 1);
      chk("R6 no overrun", overrun, 0);
      clr_irq();
      chk("R13 irq cleared", irq, 0);
      chk("R14 hs one cycle", hs_valid, 0);
      tok(2'd1, 3);
      chk("R6 overrun", overrun, 1);
      chk("R5 cnt add", fifo_cnt, 8);
      wr(8'h40);
      chk("R3 rx-done clears bit0", csr_rd, 8'h00);
      pop_n(8);
      chk("R14 pop to zero", fifo_cnt, 0);
      pop_n(1);
      chk("R14 no underflow", fifo_cnt, 0);
      clr_irq();
   endtask

   task automatic t_write_rules();
      wr(8'h15);
      chk("R2 bits 0,2,4 not set by write", csr_rd, 8'h00);
      wr(8'h20);
      chk("R2 stall request writable", csr_rd, 8'h20);
      tok(2'd1, 4);
      chk("R4 hs stall", {hs_valid, hs_code}, 3'b110);
      chk("R4 csr", csr_rd, 8'h24);
      chk("R4 cnt unchanged", fifo_cnt, 0);
      chk("R4 irq", irq, 1);
      clr_irq();
      tok(2'd2, 4);
      chk("R7 hs stall", {hs_valid, hs_code}, 3'b110);
      chk("R7 irq", irq, 1);
      wr(8'h24);
      chk("R2 bit2 kept by 1", csr_rd, 8'h24);
      wr(8'h00);
      chk("R2 bit2 cleared by 0", csr_rd, 8'h00);
      clr_irq();
   endtask

   task automatic t_in_flow();
      tok(2'd2, 6);
      chk("R8 hs nak", {hs_valid, hs_code}, 3'b101);
      chk("R8 no irq", irq, 0);
      push_n(2);
      wr(8'h02);
      chk("R10 tx-ready dropped", csr_rd, 8'h00);
      chk("R10 irq", irq, 1);
      clr_irq();
      push_n(4);
      chk("R14 push count", fifo_cnt, 6);
      wr(8'h02);
      chk("R2 tx-ready set", csr_rd, 8'h02);
      chk("R10 no irq when enough", irq, 0);
      wr(8'h00);
      chk("R2 tx-ready sticky", csr_rd, 8'h02);
      tok(2'd2, 6);
      chk("R9 hs ack", {hs_valid, hs_code}, 3'b100);
      chk("R9 csr", csr_rd, 8'h00);
      chk("R9 cnt drained", fifo_cnt, 0);
      chk("R9 irq", irq, 1);
      clr_irq();
   endtask

   task automatic t_setup_abort();
      wr(8'h0A);
      chk("R2 last-data set", csr_rd, 8'h0A);
      wr(8'h00);
      chk("R2 last-data sticky", csr_rd, 8'h0A);
      tok(2'd0, 8);
      chk("R11 csr", csr_rd, 8'h11);
      chk("R5 setup cnt", fifo_cnt, 8);
      wr(8'hC0);
      chk("R3 both serviced", csr_rd, 8'h00);
      pop_n(8);
      clr_irq();
   endtask

   task automatic t_last_data();
      tok(2'd2, 4);
      chk("R8 nak again", hs_code, 1);
      push_n(2);
      wr(8'h0A);
      chk("R10 last-data keeps tx-ready", csr_rd, 8'h0A);
      tok(2'd2, 4);
      chk("R9 last-data cleared", csr_rd, 8'h00);
      chk("R9 cnt", fifo_cnt, 0);
      clr_irq();
   endtask

   task automatic t_same_cycle();
      csr_wr_en = 1'b1; csr_wr_data = 8'h20;
      tok(2'd1, 3);
      chk("R14 write before token", {hs_valid, hs_code}, 3'b110);
      chk("R14 csr", csr_rd, 8'h24);
      wr(8'h00);
      clr_irq();
      irq_clr = 1'b1;
      tok(2'd1, 20);
      chk("R13 set wins", irq, 1);
      chk("R5 saturate", fifo_cnt, DEPTH);
      push_n(1);
      chk("R14 push at full", fifo_cnt, DEPTH);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_maxp();
      t_out_accept();
      t_write_rules();
      t_in_flow();
      t_setup_abort();
      t_last_data();
      t_same_cycle();
      finish_run();
   end

endmodule